// File: doc/BRIEF.md
# Round-Robin Replicated Processing Array

This block evaluates a fixed combinational function on a stream that can deliver one input vector per clock. Each single copy of the function still gets several clock cycles to settle. It holds `NUM_PE` identical copies of the function. A rotating load pointer steers each clock's input into the input register of one copy. That copy holds the value for `NUM_PE` cycles while its logic settles.

A result multiplexer follows the same pointer and picks the copy that is about to be reloaded. The picked result feeds one output register that updates on every clock. The stream therefore leaves at full rate, in arrival order, `NUM_PE` cycles after it entered. The function is a placeholder polynomial with coefficient parameters. The block suits any function whose logic cannot close timing in one cycle but can in `NUM_PE` cycles.

A valid bit travels with every slot. Cycles without input come out as cycles without output, and the output data is forced to zero in those cycles.

Top module: `rrpa_array`

## Requirements
- R1: While `rst` is high, and after it falls until a newly accepted input has completed, `outValid` is 0 and `outData` is 0.
- R2: An input accepted at rising edge e (`inValid` high, `rst` low) raises `outValid` at edge e+`NUM_PE`, exactly `NUM_PE` cycles later.
- R3: The result for input x is (C2·x·x + C1·x + C0) mod 2^`DATA_W`. The defaults are C2=1, C1=3, C0=7.
- R4: Inputs are accepted on every clock with no stall. Back-to-back inputs give back-to-back results, in the order the inputs arrived.
- R5: A cycle with `inValid` low gives a cycle with `outValid` low `NUM_PE` cycles later, and `outData` is 0 whenever `outValid` is 0.
- R6: Exactly one element is enabled for loading in each cycle. The enable moves from element k to element (k+1) mod `NUM_PE` on every clock, whatever `inValid` is. It starts at element 0 after reset.
- R7: The output multiplexer selects the element whose load enable is active in the same cycle. Each element's input is therefore held for `NUM_PE` full cycles before its result is captured.
- R8: Asserting `rst` in the middle of a stream discards every result still in flight; none of them appears at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks `inData` as a vector to process this cycle |
| inData | input | DATA_W | Input vector |
| outValid | output | 1 | Marks `outData` as a real result |
| outData | output | DATA_W | Function result, zero when not valid |

## Verification
The assertions assume that `rst` is held high for at least one rising edge before any stream starts. They also assume that `inValid` and `rst` are always driven to 0 or 1, never left unknown. The bench keeps within this by starting in reset with `inValid` low, and by driving every input on the falling edge from fully defined values. With the default `NUM_PE` of 4 and an 8-bit width, the stimulus sweeps every possible input value in both orders. It adds idle patterns of several densities, a run of alternating complements, and a reset in the middle of a stream. Expected results come from the polynomial and an ideal `NUM_PE`-cycle delay.

// File: rtl/rrpa_pkg.sv
package rrpa_pkg;

  // Strobes handed from the control section to the datapath each cycle.
  typedef struct packed {
    logic capture;      // current input is real; enabled element should load it
    logic resultValid;  // element being selected holds a real operand
  } rrpaStrobe_t;

endpackage

// File: rtl/rrpa_pe.sv
// One processing element: purely combinational polynomial of its operand.
module rrpa_pe #(
  parameter int DATA_W = 8,
  parameter int C2 = 1,
  parameter int C1 = 3,
  parameter int C0 = 7
) (
  input  logic [DATA_W-1:0] peIn,
  output logic [DATA_W-1:0] peOut
);

  localparam logic [DATA_W-1:0] K2 = DATA_W'(C2);
  localparam logic [DATA_W-1:0] K1 = DATA_W'(C1);
  localparam logic [DATA_W-1:0] K0 = DATA_W'(C0);

  logic [DATA_W-1:0] square;
  logic [DATA_W-1:0] quadTerm;
  logic [DATA_W-1:0] linTerm;

  always_comb begin
    square   = peIn * peIn;
    quadTerm = square * K2;
    linTerm  = peIn * K1;
    peOut    = quadTerm + linTerm + K0;
  end

endmodule

// File: rtl/rrpa_ctrl.sv
// Control: rotating load token, slot index, per-element valid flags, output valid.
module rrpa_ctrl
  import rrpa_pkg::*;
#(
  parameter int NUM_PE = 4,
  localparam int IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic [NUM_PE-1:0] loadOneHot,
  output logic [IDX_W-1:0]  selIdx,
  output rrpaStrobe_t       strobe,
  output logic              outValid
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PE - 1);

  logic [NUM_PE-1:0] token;
  logic [IDX_W-1:0]  slot;
  logic [NUM_PE-1:0] peValid;

  // The token and the slot counter advance every clock, so the window is fixed.
  always_ff @(posedge clk) begin
    if (rst) begin
      token <= NUM_PE'(1);
      slot  <= '0;
    end else begin
      token <= {token[NUM_PE-2:0], token[NUM_PE-1]};
      slot  <= (slot == LAST_IDX) ? '0 : slot + IDX_W'(1);
    end
  end

  // Element flags record whether the operand loaded into each slot is real.
  always_ff @(posedge clk) begin
    if (rst) begin
      peValid  <= '0;
      outValid <= 1'b0;
    end else begin
      peValid[slot] <= inValid;
      outValid      <= peValid[slot];
    end
  end

  assign loadOneHot         = token;
  assign selIdx             = slot;
  assign strobe.capture     = inValid;
  assign strobe.resultValid = peValid[slot];

endmodule

// File: rtl/rrpa_dp.sv
// Datapath: replicated operand registers, element logic, result mux and output register.
module rrpa_dp
  import rrpa_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int DATA_W = 8,
  parameter int C2 = 1,
  parameter int C1 = 3,
  parameter int C0 = 7,
  localparam int IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  logic [NUM_PE-1:0] loadOneHot,
  input  logic [IDX_W-1:0]  selIdx,
  input  rrpaStrobe_t       strobe,
  output logic [DATA_W-1:0] outData
);

  logic [DATA_W-1:0] peReg [NUM_PE];
  logic [DATA_W-1:0] peOut [NUM_PE];

  for (genvar k = 0; k < NUM_PE; k++) begin : g_elem
    always_ff @(posedge clk) begin
      if (rst) begin
        peReg[k] <= '0;
      end else if (loadOneHot[k] && strobe.capture) begin
        peReg[k] <= inData;
      end
    end

    rrpa_pe #(
      .DATA_W(DATA_W),
      .C2    (C2),
      .C1    (C1),
      .C0    (C0)
    ) u_pe (
      .peIn (peReg[k]),
      .peOut(peOut[k])
    );
  end

  // Selected element is the one about to reload: its operand has aged NUM_PE cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      outData <= '0;
    end else begin
      outData <= strobe.resultValid ? peOut[selIdx] : '0;
    end
  end

endmodule

// File: rtl/rrpa_array.sv
// Top: thin wrapper joining control and datapath.
module rrpa_array
  import rrpa_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int DATA_W = 8,
  parameter int C2 = 1,
  parameter int C1 = 3,
  parameter int C0 = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  localparam int IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1;

  logic [NUM_PE-1:0] loadOneHot;
  logic [IDX_W-1:0]  selIdx;
  rrpaStrobe_t       strobe;

  rrpa_ctrl #(
    .NUM_PE(NUM_PE)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .loadOneHot(loadOneHot),
    .selIdx    (selIdx),
    .strobe    (strobe),
    .outValid  (outValid)
  );

  rrpa_dp #(
    .NUM_PE(NUM_PE),
    .DATA_W(DATA_W),
    .C2    (C2),
    .C1    (C1),
    .C0    (C0)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .inData    (inData),
    .loadOneHot(loadOneHot),
    .selIdx    (selIdx),
    .strobe    (strobe),
    .outData   (outData)
  );

endmodule

// File: rtl/rrpa_array_check.sv
// Property checker, attached to every rrpa_array instance.
module rrpa_array_check #(
  parameter int NUM_PE = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic [NUM_PE-1:0] loadOneHot,
  input logic [IDX_W-1:0]  selIdx
);

  logic              armed;
  logic [NUM_PE-1:0] validLine;

  always_ff @(posedge clk) begin
    armed <= !rst;
    if (rst) begin
      validLine <= '0;
    end else begin
      validLine <= {validLine[NUM_PE-2:0], inValid};
    end
  end

  // R6: one element enabled per cycle
  p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(loadOneHot) == 1);

  // R6: enable rotates by one position every clock
  p_rotate_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    loadOneHot == {$past(loadOneHot[NUM_PE-2:0]), $past(loadOneHot[NUM_PE-1])});

  // R7: result mux follows the element being reloaded
  p_select_r7: assert property (@(posedge clk) disable iff (rst)
    loadOneHot[selIdx] == 1'b1);

  // R2: valid output exactly NUM_PE cycles after valid input
  p_latency_r2: assert property (@(posedge clk) disable iff (rst || !armed)
    outValid == $past(validLine[NUM_PE-1]));

  // R5: no data leaks out in empty slots
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    !outValid |-> outData == '0);

  // R1 and R8: reset silences the output on the next cycle
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!outValid && outData == '0));

endmodule

bind rrpa_array rrpa_array_check #(
  .NUM_PE(NUM_PE),
  .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .outValid  (outValid),
  .outData   (outData),
  .loadOneHot(loadOneHot),
  .selIdx    (selIdx)
);

// File: tb/rrpa_array_test.sv
module rrpa_array_test;

  localparam int N  = 4;
  localparam int W  = 8;
  localparam int C2 = 1;
  localparam int C1 = 3;
  localparam int C0 = 7;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [W-1:0] inData = '0;
  logic         outValid;
  logic [W-1:0] outData;

  always #10 clk = ~clk;

  rrpa_array #(.NUM_PE(N), .DATA_W(W), .C2(C2), .C1(C1), .C0(C0)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  int     checks = 0;
  int     fails  = 0;
  int     cyc    = 0;
  bit     finished = 0;
  string  tag = "R1";
  bit           hvV [N+1];
  logic [W-1:0] hvD [N+1];

  function automatic logic [W-1:0] model(input logic [W-1:0] x);
    int t;
    t = C2 * int'(x) * int'(x) + C1 * int'(x) + C0;
    return t[W-1:0];
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Check the output for the entry driven N+1 steps ago, then drive new inputs.
  task automatic step(input bit r, input bit v, input logic [W-1:0] d);
    logic [W-1:0] expD;
    @(negedge clk);
    checks++;
    expD = hvV[N] ? model(hvD[N]) : '0;
    if (outValid !== hvV[N] || outData !== expD) begin
      fails++;
      $display("FAIL %s: outValid=%0b outData=%0h expected outValid=%0b outData=%0h",
               tag, outValid, outData, hvV[N], expD);
    end
    rst = r; inValid = v; inData = d;
    if (r) begin
      for (int i = 0; i <= N; i++) hvV[i] = 1'b0;
    end else begin
      for (int i = N; i > 0; i--) begin hvV[i] = hvV[i-1]; hvD[i] = hvD[i-1]; end
      hvV[0] = v; hvD[0] = d;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected completion before 150000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i <= N; i++) begin hvV[i] = 1'b0; hvD[i] = '0; end
    // R1: reset state and quiet output afterwards
    tag = "R1";
    repeat (3) step(1, 0, '0);
    repeat (N + 2) step(0, 0, '0);
    // R2: isolated input emerges after exactly N cycles
    tag = "R2";
    step(0, 1, 8'h5A);
    repeat (N + 2) step(0, 0, '0);
    // R3: every input value through the polynomial, back to back
    tag = "R3";
    for (int v = 0; v < 256; v++) step(0, 1, W'(v));
    // R4: full-rate stream in reverse order keeps arrival order
    tag = "R4";
    for (int v = 255; v >= 0; v--) step(0, 1, W'(v));
    // R6: rotation wraps many times without disturbing results
    tag = "R6";
    for (int i = 0; i < 4 * N + 3; i++) step(0, 1, W'(i * 37 + 11));
    // R5: idle slots of several densities
    tag = "R5";
    for (int g = 1; g <= 5; g++)
      for (int i = 0; i < 40; i++) step(0, (i % (g + 1)) != 0, W'(i * 13 + g));
    repeat (N + 1) step(0, 0, '0);
    // R7: operand changes every cycle; held copies must not be disturbed
    tag = "R7";
    for (int i = 0; i < 64; i++) step(0, 1, i[0] ? ~W'(i) : W'(i));
    // R8: reset mid-stream discards in-flight results
    tag = "R8";
    for (int i = 0; i < 10; i++) step(0, 1, W'(i + 100));
    step(1, 0, '0);
    repeat (N + 1) step(0, 0, '0);
    for (int i = 0; i < N + 1; i++) step(0, 1, W'(i + 200));
    repeat (N + 2) step(0, 0, '0);
    finished = 1;
    summary();
    $finish;
  end

endmodule